// File: doc/BRIEF.md
# Multi-width UART FIFO bus port

This block is the host-facing data port of one UART channel. It sits inside a 512-byte channel window of a 32-bit memory-mapped bus. It holds that channel's 64-byte transmit FIFO and its 64-byte receive FIFO. A single host access carries a 4-bit byte-enable mask, so it can move one, two, three or four characters at once. The FIFO pointer then advances by exactly that number of characters.

A host write to the data window pushes the enabled bytes into the transmit FIFO. A host read from the same window pops characters from the receive FIFO. A second read-only window, the status window, returns every received character next to the line-status byte that arrived with it. This keeps error flags tied to their data.

On the other side, the serial logic takes characters out of the transmit FIFO one at a time. It delivers received characters, with their status, one per cycle. Offsets outside the two windows belong to other logic, such as the 16550 register file and the device configuration registers. The port returns zero for reads of those offsets and ignores writes to them.

Top module: `uart_fifo_port`

## Requirements
- R1: When `rst` is high at a clock edge, both FIFOs become empty, `tx_level` and `rx_level` read 0, `tx_ovf` reads 0, and `rsp_rdata` reads 0 from that edge on.
- R2: A write with `req_addr[8:6]` = 3'b100 (offsets 0x100 to 0x13F) pushes the enabled bytes into the transmit FIFO, lowest enabled lane first. `tx_level` rises by the number of enabled lanes at the same edge, and `tx_data` shows the oldest stored byte.
- R3: When a write carries more bytes than the free transmit space, only the lowest lanes that fit are stored and the rest are dropped. `tx_ovf` is then set, and it stays set until reset.
- R4: A read from the data window pops one receive character per enabled lane. `rsp_rdata` is loaded at that edge: the oldest character goes in the lowest enabled lane, and lanes that are not enabled read 0.
- R5: A data-window read that asks for more characters than `rx_level` holds fills the missing enabled lanes with 0 and pops only the characters present.
- R6: A status-window read (`req_addr[8:7]` = 2'b11, offsets 0x180 to 0x1FF) with byte enables 4'b0011 or 4'b1100 pops one character. It returns the data byte in the lower lane of that half-word and its status byte in the upper lane.
- R7: A status-window read with byte enables 4'b1111 pops two characters. The older one is in bits 15:0 and the newer one in bits 31:16, each as {status, data}. A missing character reads as 0.
- R8: A status-window read with any other byte-enable pattern returns 0 and pops nothing.
- R9: Reads at any offset outside the two windows return 0. Writes outside the data window, including writes to the status window, change neither FIFO.
- R10: When `rx_push` is high and `rx_level` is below 64, the pair {`rx_stat`, `rx_data`} is stored; at 64 it is dropped. When `tx_pop` is high and `tx_level` is above 0, the oldest transmit byte is removed.
- R11: If a host access and a serial-side push or pop hit the same FIFO in one cycle, the new level is the old level plus the number pushed minus the number popped. A host read sees only the characters that were present before that edge.
- R12: `tx_level` and `rx_level` stay within 0 to 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host access strobe, one cycle per access |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 9 | Byte offset inside the channel window |
| req_be | input | 4 | Byte-lane enables, bit n selects bits 8n+7:8n |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, loaded at the edge that takes the read |
| tx_pop | input | 1 | Serial side takes one transmit byte |
| tx_data | output | 8 | Oldest transmit byte, meaningful when tx_level > 0 |
| tx_level | output | 7 | Bytes held in the transmit FIFO |
| tx_ovf | output | 1 | Sticky: a host write dropped bytes |
| rx_push | input | 1 | Serial side delivers one received character |
| rx_data | input | 8 | Received data byte |
| rx_stat | input | 8 | Line-status byte for rx_data (overrun, parity, framing, break) |
| rx_level | output | 7 | Characters held in the receive FIFO |

## Verification
Two pairs of events can share a clock edge. On the receive side, a serial push can coincide with a host pop. On the transmit side, a serial pop can coincide with a host push. The bench drives both events in one cycle, first with the receive FIFO empty and then with one character held. It checks that the read returns only the characters that were already stored, and that the level moves by the exact difference. It does the same on the transmit side with one byte held, checking that `tx_data` moves on to the new byte while the level stays unchanged.

// File: rtl/uart_port_pkg.sv
package uart_port_pkg;

  localparam int LANES = 4;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_DATA = 2'd1,
    WIN_STAT = 2'd2
  } win_e;

  // number of enabled byte lanes in one access
  function automatic logic [2:0] lane_count(input logic [LANES-1:0] be);
    logic [2:0] c;
    c = '0;
    for (int i = 0; i < LANES; i++) c = c + {2'b00, be[i]};
    return c;
  endfunction

  // characters a status-window read moves: aligned half-words or full word
  function automatic logic [2:0] stat_chars(input logic [LANES-1:0] be);
    case (be)
      4'b0011, 4'b1100: return 3'd1;
      4'b1111:          return 3'd2;
      default:          return 3'd0;
    endcase
  endfunction

  // half-word where the first status character lands
  function automatic int stat_base(input logic [LANES-1:0] be);
    return (be == 4'b1100) ? 1 : 0;
  endfunction

endpackage

// File: rtl/uart_port_decode.sv
module uart_port_decode
  import uart_port_pkg::*;
(
  input  logic [2:0] win_bits,
  output win_e       win
);
  // win_bits are offset bits 8:6 of the channel window
  always_comb begin
    if (win_bits == 3'b100)      win = WIN_DATA;
    else if (win_bits[2:1] == 2'b11) win = WIN_STAT;
    else                          win = WIN_NONE;
  end
endmodule

// File: rtl/uart_port_fifo.sv
module uart_port_fifo #(
  parameter int W      = 8,
  parameter int DEPTH  = 64,
  parameter int MAXIN  = 4,
  parameter int MAXOUT = 1,
  parameter int IW     = $clog2(MAXIN + 1),
  parameter int OW     = $clog2(MAXOUT + 1),
  parameter int LW     = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [IW-1:0]              push_n,
  input  logic [MAXIN-1:0][W-1:0]    push_data,
  input  logic [OW-1:0]              pop_n,
  output logic [MAXOUT-1:0][W-1:0]   head,
  output logic [LW-1:0]              level,
  output logic [IW-1:0]              push_acc,
  output logic [OW-1:0]              pop_acc
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  // accepted counts are clamped by the space and fill seen before this edge
  always_comb begin
    int space;
    space = DEPTH - int'(level);
    push_acc = (int'(push_n) > space) ? IW'(space) : push_n;
    pop_acc  = (int'(pop_n) > int'(level)) ? OW'(level) : pop_n;
  end

  always_comb begin
    for (int k = 0; k < MAXOUT; k++) head[k] = mem[rd_ptr + AW'(k)];
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < MAXIN; k++)
      if (!rst && k < int'(push_acc)) mem[wr_ptr + AW'(k)] <= push_data[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(push_acc);
      rd_ptr <= rd_ptr + AW'(pop_acc);
      level  <= level + LW'(push_acc) - LW'(pop_acc);
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(level) <= DEPTH); // R12

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (int'(level) == DEPTH && pop_n == '0) |=> (int'(level) == DEPTH)); // R10
endmodule

// File: rtl/uart_fifo_port.sv
module uart_fifo_port
  import uart_port_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [8:0]    req_addr,
  input  logic [3:0]    req_be,
  input  logic [31:0]   req_wdata,
  output logic [31:0]   rsp_rdata,
  input  logic          tx_pop,
  output logic [7:0]    tx_data,
  output logic [LW-1:0] tx_level,
  output logic          tx_ovf,
  input  logic          rx_push,
  input  logic [7:0]    rx_data,
  input  logic [7:0]    rx_stat,
  output logic [LW-1:0] rx_level
);
  localparam int CW = $clog2(LANES + 1);

  win_e win;
  logic [CW-1:0] n_lanes, n_chars;
  logic          host_rd, host_wr, data_rd, stat_rd;
  logic [CW-1:0] tx_push_n, tx_push_acc, rx_pop_n, rx_pop_acc;
  logic [LANES-1:0][7:0]  tx_push_data;
  logic [0:0][7:0]        tx_head;
  logic                   tx_pop_acc;
  logic [0:0][15:0]       rx_push_data;
  logic [LANES-1:0][15:0] rx_head;
  logic                   rx_push_acc;
  logic [31:0]            rd_next;
  logic                   unused_bits;

  assign unused_bits = ^{req_addr[5:0], tx_pop_acc, rx_push_acc, rx_pop_acc};

  uart_port_decode u_dec (.win_bits(req_addr[8:6]), .win(win));

  always_comb begin
    n_lanes = lane_count(req_be);
    n_chars = stat_chars(req_be);
    host_rd = req_valid && !req_we;
    host_wr = req_valid && req_we && (win == WIN_DATA);
    data_rd = host_rd && (win == WIN_DATA);
    stat_rd = host_rd && (win == WIN_STAT);
    tx_push_n = host_wr ? n_lanes : '0;
    rx_pop_n  = data_rd ? n_lanes : (stat_rd ? n_chars : '0);
  end

  // pack enabled write lanes, lowest lane first
  always_comb begin
    int r;
    r = 0;
    tx_push_data = '0;
    for (int ln = 0; ln < LANES; ln++)
      if (req_be[ln]) begin
        tx_push_data[r] = req_wdata[ln*8 +: 8];
        r++;
      end
  end

  uart_port_fifo #(.W(8), .DEPTH(DEPTH), .MAXIN(LANES), .MAXOUT(1)) u_txq (
    .clk(clk), .rst(rst),
    .push_n(tx_push_n), .push_data(tx_push_data),
    .pop_n(tx_pop), .head(tx_head), .level(tx_level),
    .push_acc(tx_push_acc), .pop_acc(tx_pop_acc)
  );

  assign tx_data = tx_head[0];
  assign rx_push_data[0] = {rx_stat, rx_data};

  uart_port_fifo #(.W(16), .DEPTH(DEPTH), .MAXIN(1), .MAXOUT(LANES)) u_rxq (
    .clk(clk), .rst(rst),
    .push_n(rx_push), .push_data(rx_push_data),
    .pop_n(rx_pop_n), .head(rx_head), .level(rx_level),
    .push_acc(rx_push_acc), .pop_acc(rx_pop_acc)
  );

  // read data: only characters present before this edge are returned
  always_comb begin
    int r;
    int h0;
    r  = 0;
    h0 = stat_base(req_be);
    rd_next = '0;
    if (data_rd) begin
      for (int ln = 0; ln < LANES; ln++)
        if (req_be[ln]) begin
          if (r < int'(rx_level)) rd_next[ln*8 +: 8] = rx_head[r][7:0];
          r++;
        end
    end else if (stat_rd) begin
      for (int k = 0; k < LANES; k++)
        if (k < int'(n_chars) && k < int'(rx_level))
          rd_next[(h0 + k)*16 +: 16] = rx_head[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rsp_rdata <= '0;
    else if (host_rd) rsp_rdata <= rd_next;
  end

  always_ff @(posedge clk) begin
    if (rst)                                     tx_ovf <= 1'b0;
    else if (host_wr && tx_push_acc != n_lanes)  tx_ovf <= 1'b1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (tx_level == '0 && rx_level == '0 && !tx_ovf && rsp_rdata == '0)); // R1

  AST_FULL_WRITE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (host_wr && int'(tx_level) == DEPTH && n_lanes != '0) |=> tx_ovf); // R3

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!rst && tx_ovf) |=> tx_ovf); // R3

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (data_rd && rx_level == '0) |=> (rsp_rdata == '0)); // R5

  AST_STAT_BAD_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && n_chars == '0) |=> (rsp_rdata == '0)); // R8

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (host_rd && win == WIN_NONE) |=> (rsp_rdata == '0)); // R9

  AST_TX_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_we && win != WIN_DATA && !tx_pop)
      |=> (tx_level == $past(tx_level))); // R9
endmodule

// File: tb/sim_uart_fifo_port.sv
`timescale 1ns/1ps
module sim_uart_fifo_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [8:0]  req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        tx_pop = 1'b0;
  logic [7:0]  tx_data;
  logic [6:0]  tx_level;
  logic        tx_ovf;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_data = '0, rx_stat = '0;
  logic [6:0]  rx_level;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_fifo_port u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .tx_pop(tx_pop), .tx_data(tx_data),
    .tx_level(tx_level), .tx_ovf(tx_ovf), .rx_push(rx_push),
    .rx_data(rx_data), .rx_stat(rx_stat), .rx_level(rx_level)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // one cycle: inputs set at a falling edge, outputs sampled at the next one
  task automatic step(input logic v, input logic we, input logic [8:0] a,
                      input logic [3:0] be, input logic [31:0] d,
                      input logic rp, input logic [7:0] rd, input logic [7:0] rs,
                      input logic tp);
    @(negedge clk);
    req_valid = v; req_we = we; req_addr = a; req_be = be; req_wdata = d;
    rx_push = rp; rx_data = rd; rx_stat = rs; tx_pop = tp;
    @(negedge clk);
    req_valid = 0; rx_push = 0; tx_pop = 0;
  endtask

  // fields: we | addr(9) | be(4) | wdata(32) | exp rdata(32) | exp tx(7) | exp rx(7)
  // start: tx empty, rx holds chars i=0..7 as data 0x10+i, status i
  localparam logic [91:0] VEC [0:13] = '{
    {1'b1, 9'h100, 4'b1111, 32'h44332211, 32'h0,        7'd4, 7'd8}, // R2 dword push
    {1'b1, 9'h104, 4'b0110, 32'h00BBAA00, 32'h0,        7'd6, 7'd8}, // R2 middle lanes
    {1'b0, 9'h100, 4'b0001, 32'h0,        32'h00000010, 7'd6, 7'd7}, // R4 byte pop
    {1'b0, 9'h100, 4'b1100, 32'h0,        32'h12110000, 7'd6, 7'd5}, // R4 upper lanes
    {1'b0, 9'h180, 4'b0011, 32'h0,        32'h00000313, 7'd6, 7'd4}, // R6 low half
    {1'b0, 9'h180, 4'b1111, 32'h0,        32'h05150414, 7'd6, 7'd2}, // R7 two chars
    {1'b0, 9'h184, 4'b1100, 32'h0,        32'h06160000, 7'd6, 7'd1}, // R6 high half
    {1'b0, 9'h180, 4'b0001, 32'h0,        32'h0,        7'd6, 7'd1}, // R8 8-bit
    {1'b0, 9'h180, 4'b0111, 32'h0,        32'h0,        7'd6, 7'd1}, // R8 24-bit
    {1'b0, 9'h040, 4'b1111, 32'h0,        32'h0,        7'd6, 7'd1}, // R9 reserved read
    {1'b1, 9'h180, 4'b1111, 32'hFFFFFFFF, 32'h0,        7'd6, 7'd1}, // R9 status write
    {1'b1, 9'h140, 4'b1111, 32'hFFFFFFFF, 32'h0,        7'd6, 7'd1}, // R9 reserved write
    {1'b0, 9'h100, 4'b1111, 32'h0,        32'h00000017, 7'd6, 7'd0}, // R5 short read
    {1'b0, 9'h100, 4'b1111, 32'h0,        32'h0,        7'd6, 7'd0}  // R5 empty read
  };

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] seen [0:63];
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 tx_level after reset", 32'(tx_level), 0);
    check("R1 rx_level after reset", 32'(rx_level), 0);
    check("R1 tx_ovf after reset", 32'(tx_ovf), 0);
    check("R1 rdata after reset", rsp_rdata, 0);

    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 1, 8'(8'h10 + i), 8'(i), 0);
    check("R10 rx preload level", 32'(rx_level), 8);

    for (int i = 0; i < 14; i++) begin
      logic [91:0] v;
      v = VEC[i];
      step(1, v[91], v[90:82], v[81:78], v[77:46], 0, 0, 0, 0);
      if (!v[91]) check($sformatf("table row %0d rdata", i), rsp_rdata, v[45:14]);
      check($sformatf("table row %0d tx_level", i), 32'(tx_level), 32'(v[13:7]));
      check($sformatf("table row %0d rx_level", i), 32'(rx_level), 32'(v[6:0]));
    end

    // R2 transmit order, then drain
    begin
      logic [7:0] exp_tx [0:5];
      exp_tx = '{8'h11, 8'h22, 8'h33, 8'h44, 8'hAA, 8'hBB};
      for (int i = 0; i < 6; i++) begin
        check($sformatf("R2 tx byte %0d", i), 32'(tx_data), 32'(exp_tx[i]));
        step(0, 0, 0, 0, 0, 0, 0, 0, 1);
      end
    end
    check("R10 tx drained", 32'(tx_level), 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    check("R10 pop on empty tx", 32'(tx_level), 0);

    // R3 fill, full drop, partial drop
    for (int i = 0; i < 16; i++) step(1, 1, 9'h100, 4'hF, 32'h0, 0, 0, 0, 0);
    check("R3 tx full level", 32'(tx_level), 64);
    check("R3 no overflow at exact fill", 32'(tx_ovf), 0);
    step(1, 1, 9'h100, 4'hF, 32'hEEEEEEEE, 0, 0, 0, 0);
    check("R3 level after full write", 32'(tx_level), 64);
    check("R3 overflow set", 32'(tx_ovf), 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(1, 1, 9'h100, 4'hF, 32'hD4D3D2D1, 0, 0, 0, 0);
    check("R3 partial accept level", 32'(tx_level), 64);
    for (int i = 0; i < 64; i++) begin
      seen[i] = tx_data;
      step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    end
    check("R3 kept lane 0", 32'(seen[62]), 32'h D1);
    check("R3 kept lane 1", 32'(seen[63]), 32'h D2);
    check("R3 overflow sticky", 32'(tx_ovf), 1);
    check("R12 tx empty again", 32'(tx_level), 0);

    // R11 same-cycle host read and serial push
    step(1, 0, 9'h100, 4'hF, 0, 1, 8'h5A, 8'h03, 0);
    check("R11 read of empty with push rdata", rsp_rdata, 0);
    check("R11 level after push+read", 32'(rx_level), 1);
    step(1, 0, 9'h100, 4'h1, 0, 1, 8'h6B, 8'h00, 0);
    check("R11 read sees old char", rsp_rdata, 32'h5A);
    check("R11 level after push+pop", 32'(rx_level), 1);
    step(1, 0, 9'h1FC, 4'h3, 0, 0, 0, 0, 0);
    check("R6 status read of pushed char", rsp_rdata, 32'h0000006B);
    // R11 same-cycle host write and serial pop
    step(1, 1, 9'h100, 4'h1, 32'hC1, 0, 0, 0, 0);
    step(1, 1, 9'h100, 4'h1, 32'hC2, 0, 0, 0, 1);
    check("R11 tx level push+pop", 32'(tx_level), 1);
    check("R11 tx head after push+pop", 32'(tx_data), 32'hC2);

    // R10 receive full drop
    for (int i = 0; i < 65; i++) step(0, 0, 0, 0, 0, 1, 8'(i + 1), 8'(i), 0);
    check("R10 rx level capped", 32'(rx_level), 64);
    step(1, 0, 9'h100, 4'h1, 0, 0, 0, 0, 0);
    check("R10 oldest survives", rsp_rdata, 32'h01);
    check("R10 level after pop", 32'(rx_level), 63);

    // R1 reset while busy
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R1 mid-run tx_level", 32'(tx_level), 0);
    check("R1 mid-run rx_level", 32'(rx_level), 0);
    check("R1 mid-run tx_ovf", 32'(tx_ovf), 0);
    check("R1 mid-run rdata", rsp_rdata, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule